// File: doc/BRIEF.md
# Serial Byte Master (Mode 0 / Mode 3)

This block is the controlling end of a four-wire synchronous serial link to a single peripheral. A one-cycle start strobe launches one full-duplex byte exchange. The outgoing byte leaves on the data-out line, most significant bit first. At the same time the incoming byte is assembled from the data-in line. The serial clock is a fixed division of the system clock.

One mode input picks the serial clock's resting level: low for Mode 0 and high for Mode 3. In both modes the peripheral's data is captured on rising serial clock edges, and the outgoing data changes on falling edges. The two modes therefore differ only in the clock's resting level and in where the first change of outgoing data falls. In Mode 3 the opening falling edge only launches the most significant bit that is already on the line.

The active-low select line frames each byte with a half-period margin on both sides. The busy flag is high exactly while the frame is open. The received byte appears on the cycle the frame closes.

Top module: `serial_byte_master`

## Requirements
- R1: While reset is high, and on the first cycle after it, cs_n is 1, busy is 0, rx_byte is 0 and sck equals mode_sel.
- R2: While no frame is open, sck rests at the mode_sel level: 0 selects Mode 0 (rest low) and 1 selects Mode 3 (rest high).
- R3: A start seen while idle drives cs_n to 0 and busy to 1 on the next cycle. busy then stays high for exactly 17 × CLK_DIV/2 system cycles.
- R4: Within a frame sck makes exactly 16 transitions, 8 of them rising, with rising edges CLK_DIV cycles apart. The first transition comes CLK_DIV/2 cycles after cs_n falls.
- R5: mosi carries tx_byte bit 7 first and bit 0 last, one bit per rising sck edge. In Mode 0, bit 7 is already on mosi in the cycle cs_n falls.
- R6: miso is captured on each rising sck edge and placed MSB first into rx_byte. rx_byte changes only in the cycle busy falls and holds its value between frames.
- R7: In Mode 0 the first sck transition of a frame rises. In Mode 3 it falls, and the final transition leaves sck high.
- R8: cs_n rises no earlier than CLK_DIV/2 cycles after the last rising sck edge, with sck already at its resting level.
- R9: A start pulse while busy is high has no effect on the open frame, its length or its data.
- R10: With mosi tied to miso, sending 0x3C returns 0x3C in both modes.
- R11: mosi never changes in the same cycle that sck rises while cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a byte exchange |
| tx_byte | input | DATA_W (8) | Byte to send, sampled with start |
| mode_sel | input | 1 | 0 = Mode 0, 1 = Mode 3 |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Active-low select framing the byte |
| rx_byte | output | DATA_W (8) | Last received byte |
| busy | output | 1 | High while a frame is open |

## Verification
The exchange is run with asymmetric byte pairs such as 0xA5/0x3C and 0x9A/0xC3 in both modes. These expose bit-order reversal, off-by-one shifts and mismatched capture edges. All-ones against all-zeros, in both directions, separates stuck data from data that is merely late. A loopback run shows that launch and capture line up with no external timing slack. A start injected mid-frame tells an ignored request apart from a restart or a corrupted byte. Edge counts and spacings, measured from the select line, separate the Mode 0 opening rise from the Mode 3 opening fall.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_SHIFT = 2'd2
   } sbm_state_t;
endpackage

// File: rtl/sbm_halfcnt.sv
// Half-period tick source: pulses tick every HALF cycles while run is high.
module sbm_halfcnt #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   generate
      if (HALF < 1) begin : g_bad_half
         $error("sbm_halfcnt: HALF must be at least 1");
      end
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst || !run) begin
               cnt <= '0;
            end else if (cnt == CW'(HALF - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign tick = run && (cnt == CW'(HALF - 1));

         // R4: the counter never leaves its half-period range
         assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
            cnt <= CW'(HALF - 1));
      end
   endgenerate
endmodule

// File: rtl/sbm_txshift.sv
// Outgoing shift register, MSB presented on the line, zero fill.
module sbm_txshift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         shift,
   output logic         msb
);
   logic [W-1:0] sr;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr <= '0;
      end else if (load) begin
         sr <= ld_val;
      end else if (shift) begin
         sr <= {sr[W-2:0], 1'b0};
      end
   end

   assign msb = sr[W-1];
endmodule

// File: rtl/sbm_rxshift.sv
// Incoming shift register, new bit enters at the LSB end.
module sbm_rxshift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         capture,
   input  logic         din,
   output logic [W-1:0] word
);
   logic [W-1:0] sr;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr <= '0;
      end else if (capture) begin
         sr <= {sr[W-2:0], din};
      end
   end

   assign word = sr;
endmodule

// File: rtl/serial_byte_master.sv
module serial_byte_master #(
   parameter int DATA_W  = 8,
   parameter int CLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              mode_sel,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              cs_n,
   output logic [DATA_W-1:0] rx_byte,
   output logic              busy
);
   import sbm_pkg::*;

   localparam int HALF   = CLK_DIV / 2;
   localparam int EDGES  = 2 * DATA_W;
   localparam int ECNT_W = $clog2(EDGES + 1);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("serial_byte_master: CLK_DIV must be even and at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("serial_byte_master: DATA_W must be at least 2");
      end
   endgenerate

   sbm_state_t        state;
   logic              mode_q;
   logic              sck_q;
   logic              cs_q;
   logic              busy_q;
   logic [ECNT_W-1:0] ecnt;
   logic [DATA_W-1:0] rx_q;

   logic              run;
   logic              tick;
   logic              accept;
   logic              last_tick;
   logic              toggle;
   logic              rise;
   logic              fall;
   logic              tx_shift;
   logic [DATA_W-1:0] rx_word;

   assign run       = (state != ST_IDLE);
   assign accept    = (state == ST_IDLE) && start;
   assign last_tick = tick && (state == ST_SHIFT) && (ecnt == ECNT_W'(EDGES));
   assign toggle    = tick && ((state == ST_LEAD) ||
                               ((state == ST_SHIFT) && (ecnt != ECNT_W'(EDGES))));
   assign rise      = toggle && !sck_q;
   assign fall      = toggle &&  sck_q;
   // Mode 3 opens with a falling edge that only launches the MSB already on the line
   assign tx_shift  = fall && !(mode_q && (ecnt == '0));

   sbm_halfcnt #(.HALF(HALF)) u_half (
      .clk  (clk),
      .rst  (rst),
      .run  (run),
      .tick (tick)
   );

   sbm_txshift #(.W(DATA_W)) u_tx (
      .clk    (clk),
      .rst    (rst),
      .load   (accept),
      .ld_val (tx_byte),
      .shift  (tx_shift),
      .msb    (mosi)
   );

   sbm_rxshift #(.W(DATA_W)) u_rx (
      .clk     (clk),
      .rst     (rst),
      .capture (rise),
      .din     (miso),
      .word    (rx_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         mode_q <= 1'b0;
         sck_q  <= mode_sel;
         cs_q   <= 1'b1;
         busy_q <= 1'b0;
         ecnt   <= '0;
         rx_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               sck_q <= mode_sel;
               if (start) begin
                  mode_q <= mode_sel;
                  cs_q   <= 1'b0;
                  busy_q <= 1'b1;
                  ecnt   <= '0;
                  state  <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  sck_q <= ~sck_q;
                  ecnt  <= ECNT_W'(1);
                  state <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (last_tick) begin
                  cs_q   <= 1'b1;
                  busy_q <= 1'b0;
                  rx_q   <= rx_word;
                  state  <= ST_IDLE;
               end else if (tick) begin
                  sck_q <= ~sck_q;
                  ecnt  <= ecnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sck     = sck_q;
   assign cs_n    = cs_q;
   assign busy    = busy_q;
   assign rx_byte = rx_q;

   // R2: a settled idle line rests at the selected level
   assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && $past(state == ST_IDLE) && $stable(mode_sel)) |-> (sck == mode_sel));

   // R3: busy only ever rises in answer to a start strobe
   assert_busy_cause_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(start));

   // R4: the edge counter never runs past the frame length
   assert_edge_bound_R4: assert property (@(posedge clk) disable iff (rst)
      ecnt <= ECNT_W'(EDGES));

   // R8: the select line releases with the clock already at rest
   assert_release_rest_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> (sck == mode_q) && $stable(sck));

   // R9: a start during an open frame that is not closing keeps it open
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
      (busy && start && !last_tick) |=> busy);

   // R11: outgoing data holds across every capture edge
   assert_mosi_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && $rose(sck)) |-> $stable(mosi));
endmodule

// File: tb/serial_byte_master_bench.sv
`timescale 1ns/1ps
module serial_byte_master_bench;
   localparam int CLK_DIV = 6;
   localparam int H       = CLK_DIV / 2;

   logic       clk = 1'b0;
   logic       rst;
   logic       start;
   logic [7:0] tx_byte;
   logic       mode_sel;
   logic       miso;
   logic       sck;
   logic       mosi;
   logic       cs_n;
   logic [7:0] rx_byte;
   logic       busy;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // peripheral model controls
   logic       loop_en = 1'b0;
   logic [7:0] pat     = 8'h00;

   // monitor state, sampled on falling clk
   int   cyc = 0;
   int   nedge, rcnt, nbusy, bad_hold;
   int   cs_fall_cyc, cs_rise_cyc, first_edge_cyc, last_rise_cyc;
   int   per_min, per_max;
   logic first_edge_up, sck_at_rel, mosi_at_fall;
   logic [7:0] mcap;
   logic prev_sck = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;

   always #10 clk = ~clk;   // 50 MHz

   serial_byte_master #(.DATA_W(8), .CLK_DIV(CLK_DIV)) u_serial_byte_master (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .tx_byte  (tx_byte),
      .mode_sel (mode_sel),
      .miso     (miso),
      .sck      (sck),
      .mosi     (mosi),
      .cs_n     (cs_n),
      .rx_byte  (rx_byte),
      .busy     (busy)
   );

   always_comb begin
      if (loop_en) miso = mosi;
      else if (rcnt < 8) miso = pat[7 - rcnt];
      else miso = 1'b0;
   end

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (prev_cs && !cs_n) begin
         nedge = 0; rcnt = 0; nbusy = 0; bad_hold = 0; mcap = 8'h00;
         per_min = 1 << 30; per_max = 0; last_rise_cyc = -1;
         cs_fall_cyc = cyc; mosi_at_fall = mosi;
      end
      if (busy) nbusy = nbusy + 1;
      if (!cs_n && prev_sck != sck) begin
         if (nedge == 0) begin
            first_edge_cyc = cyc;
            first_edge_up  = sck;
         end
         nedge = nedge + 1;
         if (sck) begin
            if (mosi != prev_mosi) bad_hold = bad_hold + 1;
            mcap = {mcap[6:0], mosi};
            rcnt = rcnt + 1;
            if (last_rise_cyc >= 0) begin
               if (cyc - last_rise_cyc < per_min) per_min = cyc - last_rise_cyc;
               if (cyc - last_rise_cyc > per_max) per_max = cyc - last_rise_cyc;
            end
            last_rise_cyc = cyc;
         end
      end
      if (!prev_cs && cs_n) begin
         cs_rise_cyc = cyc;
         sck_at_rel  = sck;
      end
      prev_sck  = sck;
      prev_mosi = mosi;
      prev_cs   = cs_n;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One full frame with all its checks
   task automatic frame(input logic m, input logic [7:0] tx, input logic [7:0] slv,
                        input bit lp, input bit inject);
      logic [7:0] exp_rx;
      logic [7:0] held;
      exp_rx = lp ? tx : slv;
      @(negedge clk);
      mode_sel = m; loop_en = lp; pat = slv;
      repeat (3) @(negedge clk);
      chk(sck == m, "R2 idle level", sck, m);
      tx_byte = tx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1 && cs_n == 1'b0, "R3 open", {busy, cs_n}, 2'b10);
      if (!m) chk(mosi == tx[7], "R5 mode0 early msb", mosi, tx[7]);
      if (inject) begin
         repeat (8) @(negedge clk);
         tx_byte = ~tx; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(rx_byte == exp_rx, lp ? "R10 loopback" : "R6 rx data", rx_byte, exp_rx);
      chk(mcap == tx, inject ? "R9 tx kept" : "R5 tx order", mcap, tx);
      chk(nbusy == 17 * H, inject ? "R9 length" : "R3 busy length", nbusy, 17 * H);
      chk(nedge == 16 && rcnt == 8, "R4 edge count", nedge * 16 + rcnt, 16 * 16 + 8);
      chk(per_min == CLK_DIV && per_max == CLK_DIV, "R4 period", per_max, CLK_DIV);
      chk(first_edge_cyc - cs_fall_cyc == H, "R4 lead", first_edge_cyc - cs_fall_cyc, H);
      chk(first_edge_up == !m, "R7 first edge", first_edge_up, !m);
      chk(cs_rise_cyc - last_rise_cyc >= H, "R8 tail", cs_rise_cyc - last_rise_cyc, H);
      chk(sck_at_rel == m, "R8 rest at release", sck_at_rel, m);
      chk(bad_hold == 0, "R11 mosi hold", bad_hold, 0);
      held = rx_byte;
      pat = ~slv;
      repeat (10) @(negedge clk);
      chk(rx_byte == held && !busy && cs_n, "R6 hold", rx_byte, held);
      chk(sck == m, "R2 rest after", sck, m);
   endtask

   task automatic t_reset();
      rst = 1'b1; start = 1'b0; tx_byte = 8'h00; mode_sel = 1'b1;
      repeat (3) @(negedge clk);
      chk(cs_n && !busy && rx_byte == 8'h00 && sck == 1'b1, "R1 in reset",
          {cs_n, busy, sck}, 3'b101);
      rst = 1'b0;
      @(negedge clk);
      chk(cs_n && !busy && rx_byte == 8'h00 && sck == 1'b1, "R1 after reset",
          {cs_n, busy, sck}, 3'b101);
   endtask

   task automatic t_mode0_pattern();  frame(1'b0, 8'hA5, 8'h3C, 1'b0, 1'b0); endtask
   task automatic t_mode3_pattern();  frame(1'b1, 8'h9A, 8'hC3, 1'b0, 1'b0); endtask
   task automatic t_loop_both();      // R10
      frame(1'b0, 8'h3C, 8'h00, 1'b1, 1'b0);
      frame(1'b1, 8'h3C, 8'h00, 1'b1, 1'b0);
   endtask
   task automatic t_busy_ignore();    // R9
      frame(1'b0, 8'h5B, 8'h81, 1'b0, 1'b1);
      frame(1'b1, 8'hE4, 8'h17, 1'b0, 1'b1);
   endtask
   task automatic t_extremes();       // R5 R6 R7
      frame(1'b1, 8'hFF, 8'h00, 1'b0, 1'b0);
      frame(1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_mode0_pattern();
      t_mode3_pattern();
      t_loop_both();
      t_busy_ignore();
      t_extremes();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule